// File: doc/BRIEF.md
# Strobed 8-bit port with interrupt

This block is an 8-bit holding register with two ways of being loaded. In output mode a host writes it through a two-line device select: while the select condition is true the register follows the data input, and it holds the last value when the select goes away. In input mode an external strobe loads it in the same transparent way, and the strobe's falling edge raises a service request. The host sees that request on an active-low interrupt line and clears it by selecting the device.

An active-low clear empties the register when no load is in progress and also drops a pending request. The data output is always a plain copy of the register. A separate enable reports whether the output would drive. In output mode the enable is always on; in input mode it is on only while the device is selected.

All inputs cross into the system clock through two-flop synchronizers. The transparent behaviour is rebuilt on the clock, so every result shows up a fixed number of cycles after its cause.

Top module: `strobe_port`

## Requirements
- R1: After reset, with inputs idle (`sel_a_n`=1, `sel_b`=0, `mode`=0, `strobe`=0, `clr_n`=1), `dout` is 0x00, `dout_oe` is 0 and `irq_n` is 1.
- R2: The device counts as selected only while `sel_a_n` is 0 and `sel_b` is 1. The other three combinations leave `dout_oe` low in input mode and do not assert `irq_n`.
- R3: With `mode`=1, `dout_oe` is 1. The register follows `din` while the device is selected and keeps its value while it is not.
- R4: With `mode`=0, `dout_oe` equals the select condition. The register follows `din` while `strobe` is 1 and keeps the value it had when `strobe` fell.
- R5: With `clr_n`=0 and the load control (select in output mode, strobe in input mode) low, the register becomes 0x00. With the load control high, the register keeps following `din` and the clear has no effect.
- R6: A falling edge on `strobe`, in either mode, sets the service request, and `irq_n` goes to 0. The request stays set until select or clear removes it.
- R7: While the device is selected, `irq_n` is 0 and the service request is cleared. If a strobe fall arrives in the same cycle as the select, the select wins, so `irq_n` returns to 1 after deselection.
- R8: `clr_n`=0 clears the service request and wins over a coincident strobe fall. `irq_n` is then 1 unless the device is selected.
- R9: Every output reflects a change on the inputs at the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a_n | input | 1 | Select line, active low |
| sel_b | input | 1 | Select line, active high |
| mode | input | 1 | 1 = output mode, 0 = input mode |
| strobe | input | 1 | External load strobe; its falling edge requests service |
| clr_n | input | 1 | Active-low clear of register and request |
| din | input | 8 | Data input |
| dout | output | 8 | Register contents |
| dout_oe | output | 1 | Output drive enable; low means high-impedance |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Each input change passes two synchronizer stages and one output register, so `dout`, `dout_oe` and `irq_n` settle on the third rising edge after the change. The bench drives on a falling edge, waits three rising edges and samples on the following falling edge. A dedicated latency test samples after the second edge to confirm the old value is still present, then samples after the third edge to confirm the new one. The bound checker relates the synchronized inputs to the outputs one cycle later, which is the same timing seen from inside.

// File: rtl/strobe_port_pkg.sv
package strobe_port_pkg;

    // control part of the registered state
    typedef struct packed {
        logic stb_prev;   // strobe value of the previous cycle
        logic srq;        // service request, 1 = interrupting
        logic oe;         // registered output enable
        logic irq_n;      // registered interrupt, active low
    } ctl_t;

    localparam ctl_t CTL_RESET = '{stb_prev: 1'b0, srq: 1'b0, oe: 1'b0, irq_n: 1'b1};

    // field positions inside the synchronized input bundle
    localparam int unsigned SYN_SEL_A_N = 0;
    localparam int unsigned SYN_SEL_B   = 1;
    localparam int unsigned SYN_MODE    = 2;
    localparam int unsigned SYN_STROBE  = 3;
    localparam int unsigned SYN_CLR_N   = 4;
    localparam int unsigned SYN_CTL_W   = 5;

endpackage

// File: rtl/strobe_port_sync.sv
module strobe_port_sync #(
    parameter int unsigned       WIDTH  = 8,
    parameter int unsigned       STAGES = 2,
    parameter logic [WIDTH-1:0]  RST    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/strobe_port_latch.sv
module strobe_port_latch #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              load,
    input  logic              clr_n,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] nxt
);

    // transparent while load is high; clear only acts when closed
    always_comb begin
        if (load) begin
            nxt = din;
        end else if (!clr_n) begin
            nxt = '0;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/strobe_port_srq.sv
module strobe_port_srq (
    input  logic sel,
    input  logic clr_n,
    input  logic stb_fall,
    input  logic cur,
    output logic nxt
);

    // select and clear both dominate a coincident strobe fall
    always_comb begin
        if (sel || !clr_n) begin
            nxt = 1'b0;
        end else if (stb_fall) begin
            nxt = 1'b1;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/strobe_port.sv
module strobe_port
    import strobe_port_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              mode,
    input  logic              strobe,
    input  logic              clr_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              irq_n
);

    localparam int unsigned SW = DATA_W + SYN_CTL_W;
    localparam logic [SW-1:0] SYN_RST = {{DATA_W{1'b0}}, 5'b10001};

    logic [SW-1:0]     raw_bus;
    logic [SW-1:0]     syn_bus;
    logic              sel_a_n_s;
    logic              sel_b_s;
    logic              mode_s;
    logic              strobe_s;
    logic              clr_n_s;
    logic [DATA_W-1:0] din_s;

    logic              selected;
    logic              load;
    logic              stb_fall;
    logic [DATA_W-1:0] data_nxt;
    logic              srq_nxt;

    ctl_t              ctl_d;
    ctl_t              ctl_q;
    logic [DATA_W-1:0] data_d;
    logic [DATA_W-1:0] data_q;

    assign raw_bus = {din, clr_n, strobe, mode, sel_b, sel_a_n};

    strobe_port_sync #(
        .WIDTH  (SW),
        .STAGES (SYNC_STAGES),
        .RST    (SYN_RST)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_bus),
        .sync_o  (syn_bus)
    );

    assign sel_a_n_s = syn_bus[SYN_SEL_A_N];
    assign sel_b_s   = syn_bus[SYN_SEL_B];
    assign mode_s    = syn_bus[SYN_MODE];
    assign strobe_s  = syn_bus[SYN_STROBE];
    assign clr_n_s   = syn_bus[SYN_CLR_N];
    assign din_s     = syn_bus[SW-1:SYN_CTL_W];

    assign selected = !sel_a_n_s && sel_b_s;
    assign load     = mode_s ? selected : strobe_s;
    assign stb_fall = ctl_q.stb_prev && !strobe_s;

    strobe_port_latch #(
        .DATA_W (DATA_W)
    ) latch_i (
        .load  (load),
        .clr_n (clr_n_s),
        .din   (din_s),
        .cur   (data_q),
        .nxt   (data_nxt)
    );

    strobe_port_srq srq_i (
        .sel      (selected),
        .clr_n    (clr_n_s),
        .stb_fall (stb_fall),
        .cur      (ctl_q.srq),
        .nxt      (srq_nxt)
    );

    always_comb begin
        ctl_d          = ctl_q;
        data_d         = data_nxt;
        ctl_d.stb_prev = strobe_s;
        ctl_d.srq      = srq_nxt;
        ctl_d.oe       = mode_s || selected;
        ctl_d.irq_n    = !(srq_nxt || selected);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= CTL_RESET;
            data_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            data_q <= data_d;
        end
    end

    assign dout    = data_q;
    assign dout_oe = ctl_q.oe;
    assign irq_n   = ctl_q.irq_n;

endmodule

// File: rtl/strobe_port_chk.sv
module strobe_port_chk #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a_n_s,
    input  logic              sel_b_s,
    input  logic              mode_s,
    input  logic              strobe_s,
    input  logic              clr_n_s,
    input  logic [DATA_W-1:0] din_s,
    input  logic [DATA_W-1:0] dout,
    input  logic              dout_oe,
    input  logic              irq_n
);

    logic sel_c;
    logic load_c;
    logic stb_seen_q;

    assign sel_c  = !sel_a_n_s && sel_b_s;
    assign load_c = mode_s ? sel_c : strobe_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stb_seen_q <= 1'b0;
        else        stb_seen_q <= strobe_s;
    end

    a_r3_out_mode_drives: assert property (@(posedge clk) disable iff (!rst_n)
        mode_s |=> dout_oe);

    a_r4_idle_floats: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_s && !sel_c) |=> !dout_oe);

    a_r2_select_drives: assert property (@(posedge clk) disable iff (!rst_n)
        sel_c |=> dout_oe);

    a_r5_load_follows: assert property (@(posedge clk) disable iff (!rst_n)
        load_c |=> (dout == $past(din_s)));

    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_c && !clr_n_s) |=> (dout == '0));

    a_r4_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_c && clr_n_s) |=> $stable(dout));

    a_r7_select_irq: assert property (@(posedge clk) disable iff (!rst_n)
        sel_c |=> !irq_n);

    a_r8_clear_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n_s && !sel_c) |=> irq_n);

    a_r6_fall_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_seen_q && !strobe_s && clr_n_s) |=> !irq_n);

endmodule

bind strobe_port strobe_port_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_a_n_s (sel_a_n_s),
    .sel_b_s   (sel_b_s),
    .mode_s    (mode_s),
    .strobe_s  (strobe_s),
    .clr_n_s   (clr_n_s),
    .din_s     (din_s),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .irq_n     (irq_n)
);

// File: tb/strobe_port_tb_top.sv
module strobe_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_a_n = 1'b1;
    logic       sel_b = 1'b0;
    logic       mode = 1'b0;
    logic       strobe = 1'b0;
    logic       clr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    strobe_port dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_a_n (sel_a_n),
        .sel_b   (sel_b),
        .mode    (mode),
        .strobe  (strobe),
        .clr_n   (clr_n),
        .din     (din),
        .dout    (dout),
        .dout_oe (dout_oe),
        .irq_n   (irq_n)
    );

    // {sel_a_n, sel_b, mode, strobe, clr_n, din, exp_dout, exp_oe, exp_irq_n}
    localparam int NV = 29;
    localparam logic [22:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,1'b1,8'hA5,8'h00,1'b0,1'b1}, //  0 R1 idle
        {1'b1,1'b0,1'b0,1'b1,1'b1,8'h3C,8'h3C,1'b0,1'b1}, //  1 R4 strobe open
        {1'b1,1'b0,1'b0,1'b1,1'b1,8'hC3,8'hC3,1'b0,1'b1}, //  2 R4 follows
        {1'b1,1'b0,1'b0,1'b0,1'b1,8'h77,8'hC3,1'b0,1'b0}, //  3 R4 R6 fall
        {1'b1,1'b0,1'b0,1'b0,1'b1,8'h11,8'hC3,1'b0,1'b0}, //  4 R6 stays
        {1'b0,1'b1,1'b0,1'b0,1'b1,8'h11,8'hC3,1'b1,1'b0}, //  5 R4 R7 select
        {1'b1,1'b0,1'b0,1'b0,1'b1,8'h11,8'hC3,1'b0,1'b1}, //  6 R7 cleared
        {1'b0,1'b0,1'b0,1'b0,1'b1,8'h11,8'hC3,1'b0,1'b1}, //  7 R2 half
        {1'b1,1'b1,1'b0,1'b0,1'b1,8'h11,8'hC3,1'b0,1'b1}, //  8 R2 half
        {1'b1,1'b0,1'b1,1'b0,1'b1,8'h5A,8'hC3,1'b1,1'b1}, //  9 R3 unselected
        {1'b0,1'b1,1'b1,1'b0,1'b1,8'h5A,8'h5A,1'b1,1'b0}, // 10 R3 write
        {1'b0,1'b1,1'b1,1'b0,1'b1,8'h99,8'h99,1'b1,1'b0}, // 11 R3 follows
        {1'b1,1'b0,1'b1,1'b0,1'b1,8'h00,8'h99,1'b1,1'b1}, // 12 R3 holds
        {1'b1,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b1}, // 13 R5 clear
        {1'b0,1'b1,1'b1,1'b0,1'b1,8'hE7,8'hE7,1'b1,1'b0}, // 14 R3
        {1'b0,1'b1,1'b1,1'b0,1'b0,8'h42,8'h42,1'b1,1'b0}, // 15 R5 override
        {1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'h42,1'b0,1'b1}, // 16 R4
        {1'b1,1'b0,1'b0,1'b1,1'b1,8'h81,8'h81,1'b0,1'b1}, // 17 R4
        {1'b1,1'b0,1'b0,1'b1,1'b0,8'h81,8'h81,1'b0,1'b1}, // 18 R5 override
        {1'b1,1'b0,1'b0,1'b0,1'b0,8'h81,8'h00,1'b0,1'b1}, // 19 R8 clear wins
        {1'b1,1'b0,1'b0,1'b1,1'b1,8'h24,8'h24,1'b0,1'b1}, // 20 R4
        {1'b1,1'b0,1'b0,1'b0,1'b1,8'h24,8'h24,1'b0,1'b0}, // 21 R6 set
        {1'b1,1'b0,1'b0,1'b0,1'b0,8'h24,8'h00,1'b0,1'b1}, // 22 R8 clears
        {1'b1,1'b0,1'b0,1'b1,1'b1,8'h6B,8'h6B,1'b0,1'b1}, // 23 R4
        {1'b0,1'b1,1'b0,1'b0,1'b1,8'h6B,8'h6B,1'b1,1'b0}, // 24 R7 fall+select
        {1'b1,1'b0,1'b0,1'b0,1'b1,8'h6B,8'h6B,1'b0,1'b1}, // 25 R7 select won
        {1'b1,1'b0,1'b1,1'b1,1'b1,8'h6B,8'h6B,1'b1,1'b1}, // 26 R6 output mode
        {1'b1,1'b0,1'b1,1'b0,1'b1,8'h6B,8'h6B,1'b1,1'b0}, // 27 R6 output mode
        {1'b1,1'b0,1'b1,1'b0,1'b0,8'h6B,8'h00,1'b1,1'b1}  // 28 R5 R8
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [22:0] v);
        {sel_a_n, sel_b, mode, strobe, clr_n, din} = v[22:10];
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 dout", dout, 8'h00);
        check("R1 oe", {7'd0, dout_oe}, 8'h00);
        check("R1 irq_n", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 dout after release", dout, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            repeat (3) @(posedge clk);
            @(negedge clk);
            check($sformatf("vec %0d dout", i), dout, VEC[i][9:2]);
            check($sformatf("vec %0d oe", i), {7'd0, dout_oe}, {7'd0, VEC[i][1]});
            check($sformatf("vec %0d irq_n", i), {7'd0, irq_n}, {7'd0, VEC[i][0]});
        end

        // R9 latency: output mode write, selected, clear released
        drive({1'b0,1'b1,1'b1,1'b0,1'b1,8'h3F,8'h00,1'b0,1'b0});
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R9 dout before edge 3", dout, 8'h00);
        check("R9 irq_n before edge 3", {7'd0, irq_n}, 8'h01);
        @(posedge clk);
        @(negedge clk);
        check("R9 dout at edge 3", dout, 8'h3F);
        check("R9 irq_n at edge 3", {7'd0, irq_n}, 8'h00);

        // R1: reset while a request is pending
        drive({1'b1,1'b0,1'b0,1'b1,1'b1,8'h55,8'h00,1'b0,1'b0});
        repeat (4) @(negedge clk);
        drive({1'b1,1'b0,1'b0,1'b0,1'b1,8'h55,8'h00,1'b0,1'b0});
        repeat (4) @(negedge clk);
        check("R6 pending before reset", {7'd0, irq_n}, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 dout in reset", dout, 8'h00);
        check("R1 oe in reset", {7'd0, dout_oe}, 8'h00);
        check("R1 irq_n in reset", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);

        done = 1'b1;
        finish_run();
    end

endmodule